// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through

This block is a word-wide first-in first-out buffer between two unrelated clock domains. A write port on one clock stores words into a dual-port memory, and a read port on the other clock returns them in the same order. Each pointer crosses into the other domain as a Gray code through a chain of synchronising flops. Every status flag is computed in the domain of the port it gates.

The output behaviour is fixed during master reset by the level of `mode_i`. In standard mode a word is fetched only on request: it appears on the data output after the read edge that accepts the read enable. In fall-through mode the oldest stored word is moved into the output register without being asked for. That register holds one word, so the buffer holds one word more than the memory depth.

The flag pins change their polarity with the mode. In standard mode, high means "go": data is available, or space is free. In fall-through mode, low means "go". A partial reset empties the buffer but keeps the mode that was latched. A retransmit rewinds the read side to the first word written since the last reset, so the stored data can be read again.

Top module: `dcfifo_ft`

## Requirements
- R1: `mode_i` is sampled only while `rst_ni` is low; 0 selects standard mode, 1 selects fall-through mode. Changes to `mode_i` after reset have no effect on flag polarity or behaviour.
- R2: In standard mode, `rd_flag_o` is 1 while at least one word can be read and 0 when empty. `wr_flag_o` is 1 while space remains and 0 once DEPTH words are held.
- R3: A write while no space remains and a read while no word is available are ignored. No word is stored or lost, and the order of later data is unchanged.
- R4: In standard mode, an accepted read places the oldest word on `rd_data_o` at the read-clock edge that accepts it. Words leave in the order they were written.
- R5: In fall-through mode, the oldest word appears on `rd_data_o`, with `rd_flag_o` at 0, without any read enable. A read enable while `rd_flag_o` is 0 consumes that word and advances to the next.
- R6: In fall-through mode, the buffer accepts DEPTH+1 words with no reads. `wr_flag_o` is 0 while space remains and becomes 1 once DEPTH+1 words are held.
- R7: `half_o`, in the write domain, is 1 when more than DEPTH/2 words are held in the memory array, and 0 otherwise.
- R8: Driving `prst_ni` low empties the buffer and returns both pointers to the first location. The latched mode is kept.
- R9: After master reset the buffer is empty, `half_o` is 0, and the flags show empty and not full in the polarity of the selected mode.
- R10: `rt_i` high with `rd_en_i` low at a read-clock edge rewinds the read pointer to the first location, so the words written since reset are read again from the first one. When `rd_en_i` is high in the same cycle, `rt_i` is ignored and the cycle is a normal read. Retransmit is valid while at most DEPTH-2 words have been written since reset and the write port is idle.
- R11: In standard mode, `rd_flag_o` reads 0 (empty) for the read cycle that follows a retransmit edge, and reads are blocked in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Master reset, active low; latches the mode |
| prst_ni | input | 1 | Partial reset, active low; clears data and pointers only |
| mode_i | input | 1 | Mode select sampled during master reset (0 standard, 1 fall-through) |
| wr_en_i | input | 1 | Write enable |
| wr_data_i | input | DATA_W | Write data |
| wr_flag_o | output | 1 | Space flag; polarity set by mode |
| half_o | output | 1 | More than half of the memory array occupied |
| rd_en_i | input | 1 | Read enable |
| rt_i | input | 1 | Retransmit request |
| rd_data_o | output | DATA_W | Read data register |
| rd_flag_o | output | 1 | Data flag; polarity set by mode |

## Verification
Results in one domain are due at fixed points. The standard-mode read word appears at the read edge that accepts the enable. The write-side full and half flags move at the write edge that accepts the write. The bench samples both at the next falling edge of that clock. Results that cross domains pass through a pointer register and two synchroniser flops, and in fall-through mode also the output register load. Examples are the empty flag clearing after a write, space reappearing after a read, and the first fall-through word. These are due within four edges of the receiving clock, so the bench waits eight read cycles before checking them. The scoreboard compares each word at the point it is due: one falling edge after the accepting edge in standard mode, and before the consuming edge in fall-through mode.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;
endpackage

// File: rtl/dcfifo_mem.sv
module dcfifo_mem #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         clr_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge clr_ni) begin
        if (!clr_ni) st_q[0] <= '0;
        else         st_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge clr_ni) begin
        if (!clr_ni) st_q[s] <= '0;
        else         st_q[s] <= st_q[s-1];
      end
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/dcfifo_wr_ctrl.sv
module dcfifo_wr_ctrl
  import dcfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_ni,
  input  logic          mode_i,
  input  logic          wr_en_i,
  input  logic [PW-1:0] rgray_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [PW-1:0] wgray_o,
  output logic          flag_o,
  output logic          half_o
);
  function automatic logic [PW-1:0] to_gray(logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] to_bin(logic [PW-1:0] g);
    logic [PW-1:0] b;
    b = g;
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  fifo_mode_e    mode_q;
  logic [PW-1:0] wbin_q, wgray_q, rbin, count, wbin_d;
  logic          full;

  // mode is captured only while master reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) mode_q <= mode_i ? MODE_FWFT : MODE_STD;
  end

  assign rbin   = to_bin(rgray_i);
  assign count  = wbin_q - rbin;
  assign full   = (count == PW'(DEPTH));
  assign we_o   = wr_en_i & ~full;
  assign wbin_d = we_o ? wbin_q + PW'(1) : wbin_q;

  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= to_gray(wbin_d);
    end
  end

  assign waddr_o = wbin_q[AW-1:0];
  assign wgray_o = wgray_q;
  assign flag_o  = (mode_q == MODE_FWFT) ? full : ~full;
  assign half_o  = (count > PW'(DEPTH / 2));

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!clr_ni)
    count <= PW'(DEPTH));
  a_r3_full_write_dropped: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (wr_en_i && full) |=> $stable(wgray_o));
  a_r4_wgray_step: assert property (@(posedge clk_i) disable iff (!clr_ni)
    $countones(wgray_o ^ $past(wgray_o)) <= 1);
endmodule

// File: rtl/dcfifo_rd_ctrl.sv
module dcfifo_rd_ctrl
  import dcfifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_ni,
  input  logic              mode_i,
  input  logic              rd_en_i,
  input  logic              rt_i,
  input  logic [PW-1:0]     wgray_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [AW-1:0]     raddr_o,
  output logic [PW-1:0]     rgray_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              flag_o
);
  function automatic logic [PW-1:0] to_gray(logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] to_bin(logic [PW-1:0] g);
    logic [PW-1:0] b;
    b = g;
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  fifo_mode_e        mode_q;
  logic [PW-1:0]     rbin_q, rgray_q, rbin_d, wbin;
  logic [DATA_W-1:0] dout_q;
  logic              hold_q, vld_q;
  logic              fwft, ram_empty, empty_std, rt_eff, pop;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) mode_q <= mode_i ? MODE_FWFT : MODE_STD;
  end

  assign fwft      = (mode_q == MODE_FWFT);
  assign wbin      = to_bin(wgray_i);
  assign ram_empty = (rbin_q == wbin);
  assign rt_eff    = rt_i & ~rd_en_i;
  assign empty_std = ram_empty | hold_q;
  // fall-through refills the output register whenever it is free or being consumed
  assign pop = fwft ? (~ram_empty & ~hold_q & (~vld_q | rd_en_i))
                    : (rd_en_i & ~empty_std);

  always_comb begin
    if (rt_eff)   rbin_d = '0;
    else if (pop) rbin_d = rbin_q + PW'(1);
    else          rbin_d = rbin_q;
  end

  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      dout_q  <= '0;
      hold_q  <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= to_gray(rbin_d);
      hold_q  <= rt_eff;
      if (rt_eff) begin
        vld_q <= 1'b0;
      end else begin
        if (pop) dout_q <= rdata_i;
        if (fwft) begin
          if (pop)          vld_q <= 1'b1;
          else if (rd_en_i) vld_q <= 1'b0;
        end
      end
    end
  end

  assign raddr_o   = rbin_q[AW-1:0];
  assign rgray_o   = rgray_q;
  assign rd_data_o = dout_q;
  assign flag_o    = fwft ? ~vld_q : ~empty_std;

  a_r3_no_underrun: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (wbin - rbin_q) <= PW'(DEPTH));
  a_r3_empty_read_dropped: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (!fwft && flag_o == 1'b0 && rd_en_i) |=> $stable(raddr_o));
  a_r5_fwft_hold: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (fwft && flag_o == 1'b0 && !rd_en_i && !rt_i) |=> (flag_o == 1'b0) && $stable(rd_data_o));
  a_r10_rewind: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (rt_i && !rd_en_i) |=> (raddr_o == '0));
  a_r11_std_gap: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (!fwft && rt_i && !rd_en_i) |=> (flag_o == 1'b0));
endmodule

// File: rtl/dcfifo_ft.sv
module dcfifo_ft #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int SYNC_STAGES = 2,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              prst_ni,
  input  logic              mode_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_flag_o,
  output logic              half_o,
  input  logic              rd_en_i,
  input  logic              rt_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_flag_o
);
  logic              clr_n;
  logic              we;
  logic [AW-1:0]     waddr, raddr;
  logic [PW-1:0]     wgray, rgray, wgray_rs, rgray_ws;
  logic [DATA_W-1:0] rdata;

  assign clr_n = rst_ni & prst_ni;

  dcfifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .wclk_i (wclk_i),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(wr_data_i),
    .raddr_i(raddr),
    .rdata_o(rdata)
  );

  dcfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk_i (rclk_i),
    .clr_ni(clr_n),
    .d_i   (wgray),
    .q_o   (wgray_rs)
  );

  dcfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk_i (wclk_i),
    .clr_ni(clr_n),
    .d_i   (rgray),
    .q_o   (rgray_ws)
  );

  dcfifo_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk_i  (wclk_i),
    .rst_ni (rst_ni),
    .clr_ni (clr_n),
    .mode_i (mode_i),
    .wr_en_i(wr_en_i),
    .rgray_i(rgray_ws),
    .we_o   (we),
    .waddr_o(waddr),
    .wgray_o(wgray),
    .flag_o (wr_flag_o),
    .half_o (half_o)
  );

  dcfifo_rd_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd (
    .clk_i    (rclk_i),
    .rst_ni   (rst_ni),
    .clr_ni   (clr_n),
    .mode_i   (mode_i),
    .rd_en_i  (rd_en_i),
    .rt_i     (rt_i),
    .wgray_i  (wgray_rs),
    .rdata_i  (rdata),
    .raddr_o  (raddr),
    .rgray_o  (rgray),
    .rd_data_o(rd_data_o),
    .flag_o   (rd_flag_o)
  );
endmodule

// File: tb/dcfifo_ft_tb.sv
`timescale 1ns/1ps
module dcfifo_ft_tb;
  localparam int DW    = 16;
  localparam int DEPTH = 16;

  logic          wclk = 1'b0, rclk = 1'b0;
  logic          rst_n = 1'b0, prst_n = 1'b1, mode = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0, rt = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_flag, half, rd_flag;
  logic [DW-1:0] rd_data;

  int            checks = 0, fails = 0;
  bit            fwft_b = 1'b0;
  string         req_s = "R4";
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] hist[$];
  event          pop_ev;

  always #2 wclk = ~wclk;
  initial begin
    #1.25;
    forever #3.5 rclk = ~rclk;
  end

  dcfifo_ft #(.DATA_W(DW), .DEPTH(DEPTH)) u_dut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .prst_ni(prst_n),
    .mode_i(mode), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .wr_flag_o(wr_flag), .half_o(half), .rd_en_i(rd_en), .rt_i(rt),
    .rd_data_o(rd_data), .rd_flag_o(rd_flag)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(pop_ev) begin
    if (exp_q.size() == 0) chk(1'b0, {req_s, " unexpected word"}, int'(rd_data), 0);
    else begin
      logic [DW-1:0] e;
      e = exp_q.pop_front();
      chk(rd_data == e, {req_s, " data order"}, int'(rd_data), int'(e));
    end
  end

  task automatic settle();
    repeat (8) @(negedge rclk);
  endtask

  task automatic do_reset(bit m);
    @(negedge rclk);
    rst_n = 1'b0; mode = m;
    repeat (4) @(negedge rclk);
    rst_n = 1'b1;
    fwft_b = m;
    exp_q.delete(); hist.delete();
    settle();
  endtask

  task automatic wr_word(logic [DW-1:0] v);
    @(negedge wclk);
    if (fwft_b ? !wr_flag : wr_flag) begin
      wr_en = 1'b1; wr_data = v;
      exp_q.push_back(v); hist.push_back(v);
      @(negedge wclk);
      wr_en = 1'b0;
    end else chk(1'b0, "R2 no space for write", int'(wr_flag), int'(fwft_b));
  endtask

  task automatic rd_word(bit with_rt);
    @(negedge rclk);
    if (fwft_b) begin
      if (!rd_flag) begin
        -> pop_ev;
        rd_en = 1'b1; rt = with_rt;
        @(negedge rclk);
        rd_en = 1'b0; rt = 1'b0;
      end else chk(1'b0, "R5 no word ready", int'(rd_flag), 0);
    end else begin
      if (rd_flag) begin
        rd_en = 1'b1; rt = with_rt;
        @(negedge rclk);
        rd_en = 1'b0; rt = 1'b0;
        -> pop_ev;
      end else chk(1'b0, "R2 no word ready", int'(rd_flag), 1);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    // R9 / R1 standard mode reset state
    do_reset(1'b0);
    chk(rd_flag == 1'b0, "R9 std empty flag", int'(rd_flag), 0);
    chk(wr_flag == 1'b1, "R9 std space flag", int'(wr_flag), 1);
    chk(half == 1'b0, "R9 half after reset", int'(half), 0);
    mode = 1'b1;
    settle();
    chk(rd_flag == 1'b0 && wr_flag == 1'b1, "R1 mode change ignored", int'({rd_flag, wr_flag}), 1);

    // R2 / R4 basic transfer
    req_s = "R4";
    for (int i = 0; i < 3; i++) wr_word(DW'(16'h100 + i));
    settle();
    chk(rd_flag == 1'b1, "R2 data available", int'(rd_flag), 1);
    for (int i = 0; i < 3; i++) rd_word(1'b0);
    settle();
    chk(rd_flag == 1'b0, "R2 empty after drain", int'(rd_flag), 0);

    // R3 read while empty is dropped
    @(negedge rclk) rd_en = 1'b1;
    @(negedge rclk) rd_en = 1'b0;
    settle();
    chk(rd_flag == 1'b0, "R3 empty read no effect", int'(rd_flag), 0);
    req_s = "R3";
    wr_word(16'h0077);
    settle();
    rd_word(1'b0);

    // R7 / R2 / R3 fill to full
    do_reset(1'b0);
    req_s = "R3";
    for (int i = 0; i < DEPTH; i++) begin
      wr_word(DW'(16'h200 + i));
      if (i == DEPTH / 2 - 1) chk(half == 1'b0, "R7 half at DEPTH/2", int'(half), 0);
      if (i == DEPTH / 2)     chk(half == 1'b1, "R7 half above DEPTH/2", int'(half), 1);
    end
    chk(wr_flag == 1'b0, "R2 full after DEPTH writes", int'(wr_flag), 0);
    @(negedge wclk); wr_en = 1'b1; wr_data = 16'hdead;
    @(negedge wclk); wr_en = 1'b0;
    chk(wr_flag == 1'b0, "R3 still full", int'(wr_flag), 0);
    settle();
    for (int i = 0; i < DEPTH; i++) rd_word(1'b0);
    settle();
    chk(rd_flag == 1'b0, "R3 overflow word not stored", int'(rd_flag), 0);
    chk(half == 1'b0, "R7 half clear after drain", int'(half), 0);

    // R10 / R11 retransmit
    do_reset(1'b0);
    req_s = "R10";
    for (int i = 0; i < 5; i++) wr_word(DW'(16'h300 + i));
    settle();
    rd_word(1'b0); rd_word(1'b0);
    @(negedge rclk) rt = 1'b1;
    @(negedge rclk) rt = 1'b0;
    chk(rd_flag == 1'b0, "R11 empty after retransmit edge", int'(rd_flag), 0);
    settle();
    chk(rd_flag == 1'b1, "R10 data after rewind", int'(rd_flag), 1);
    exp_q = hist;
    for (int i = 0; i < 5; i++) rd_word(1'b0);
    wr_word(16'h0401); wr_word(16'h0402);
    settle();
    rd_word(1'b1);  // R10: rt with rd_en is a normal read
    rd_word(1'b0);
    settle();
    chk(rd_flag == 1'b0, "R10 ignored rt no rewind", int'(rd_flag), 0);

    // R9 / R5 fall-through mode
    do_reset(1'b1);
    chk(rd_flag == 1'b1, "R9 fwft empty flag", int'(rd_flag), 1);
    chk(wr_flag == 1'b0, "R9 fwft space flag", int'(wr_flag), 0);
    req_s = "R5";
    wr_word(16'h1234);
    settle();
    chk(rd_flag == 1'b0, "R5 word ready without read", int'(rd_flag), 0);
    chk(rd_data == 16'h1234, "R5 word on output", int'(rd_data), 16'h1234);
    rd_word(1'b0);
    for (int i = 0; i < 3; i++) wr_word(DW'(16'h500 + i));
    settle();
    for (int i = 0; i < 3; i++) rd_word(1'b0);
    settle();
    chk(rd_flag == 1'b1, "R5 empty after drain", int'(rd_flag), 1);

    // R6 capacity DEPTH+1
    req_s = "R6";
    for (int i = 0; i < DEPTH; i++) wr_word(DW'(16'h600 + i));
    settle();
    chk(wr_flag == 1'b0, "R6 space for one more", int'(wr_flag), 0);
    wr_word(16'h06ff);
    chk(wr_flag == 1'b1, "R6 blocked at DEPTH+1", int'(wr_flag), 1);
    for (int i = 0; i < DEPTH + 1; i++) rd_word(1'b0);
    settle();

    // R8 partial reset keeps mode
    for (int i = 0; i < 4; i++) wr_word(DW'(16'h700 + i));
    settle();
    @(negedge rclk) prst_n = 1'b0;
    repeat (3) @(negedge rclk);
    prst_n = 1'b1;
    exp_q.delete(); hist.delete();
    settle();
    chk(rd_flag == 1'b1, "R8 empty after partial reset", int'(rd_flag), 1);
    chk(wr_flag == 1'b0, "R8 fwft polarity kept", int'(wr_flag), 0);
    req_s = "R8";
    wr_word(16'h0abc);
    settle();
    chk(rd_flag == 1'b0 && rd_data == 16'h0abc, "R8 fall-through after partial reset",
        int'(rd_data), 16'h0abc);
    rd_word(1'b0);
    settle();
    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule